// File: doc/BRIEF.md
# UART Receive Error-Status Register

This block is the 16-bit status register of a UART whose receiver feeds a 16-entry FIFO. Every byte that enters the FIFO carries two error tags, one for a parity error and one for a framing error. The upper byte of the register holds two 4-bit counts. Each count gives the number of bytes now in the FIFO that carry that error. The counts follow bytes as they are pushed in and popped out. Bits 3 and 2 show the error tags of the byte at the head of the FIFO.

The other six bits of the lower byte are operating-state flags. Hardware sets them through a set-event input. Software clears a flag by reading the register while the flag is 1 and then writing 0 to that bit. If a flag is set again between the read and the write, the new event survives the write. A CPU write can never set a flag.

The block keeps only the error tags of the FIFO entries. The data bytes, the shifter, the baud logic and the interrupt logic are outside it. `cpu_rdata` is combinational from the register state, so a read returns the current value in the same cycle.

Top module: `uart_rxerr_status`

## Requirements
- R1: `cpu_rdata[15:12]` is the number of FIFO entries with a parity tag, modulo 16. `cpu_rdata[11:8]` is the number with a framing tag, modulo 16.
- R2: When all 16 FIFO entries carry a given error tag, that count reads 0.
- R3: CPU writes have no effect on bits 15:8.
- R4: Bit 3 is the framing tag and bit 2 the parity tag of the head entry. Both read 0 when the FIFO is empty, and CPU writes do not change them.
- R5: Writing 1 to a clearable flag bit (7, 6, 5, 4, 1, 0) leaves that bit unchanged, including a bit that is 0.
- R6: A write of 0 clears a flag only if an earlier `cpu_rd` saw that flag at 1 after its last hardware set. Otherwise the flag stays 1.
- R7: After reset, `cpu_rdata` reads 0x0060.
- R8: `flag_set[i]` sets a flag in the next cycle. The mapping of index to register bit is 0→0, 1→1, 2→4, 3→5, 4→6, 5→7.
- R9: An accepted push with a given tag raises that count by one. An accepted pop of a tagged entry lowers it by one. A push and a pop of tagged entries in the same cycle leave it unchanged. A pop of an empty FIFO does nothing.
- R10: A hardware set that arrives between the qualifying read and the write of 0 survives that write.
- R11: If a hardware set and a qualifying clear write happen in the same cycle, the flag ends at 1.
- R12: A push into a full FIFO is dropped and changes neither count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_rd | input | 1 | CPU read strobe; records which flags were seen set |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Current register value |
| rx_push | input | 1 | Receiver pushes one byte into the FIFO |
| rx_push_perr | input | 1 | Parity tag of the pushed byte |
| rx_push_ferr | input | 1 | Framing tag of the pushed byte |
| rx_pop | input | 1 | CPU pops the head byte |
| flag_set | input | 6 | Hardware set events for the clearable flags |

## Verification
The bench fills the FIFO with 16 bytes that carry both errors and checks that both counts read 0. It then pushes a 17th byte, which must be dropped; a design that accepted it, or saturated the count, would show 1 or 15. Simultaneous push and pop with different tags are checked to show that each count moves by its own tag and not by the push alone. For the flags, the bench writes 0 with no read first, lets a set event arrive between the read and the write, and makes a set coincide with the clear. A design that clears without the read, forgets to drop the read marker on a new set, or lets the clear win would lose a flag that must stay 1.

// File: rtl/rxst_pkg.sv
package rxst_pkg;

  localparam int NUM_FLAGS = 6;
  localparam int REG_W     = 16;

  // Reset pattern on the flag vector (flag indices 3 and 4 -> bits 5 and 6).
  localparam logic [NUM_FLAGS-1:0] FLAG_RST = 6'b011000;

  // Register bit that carries clearable flag i.
  function automatic int flag_pos(input int idx);
    case (idx)
      0: flag_pos = 0;
      1: flag_pos = 1;
      2: flag_pos = 4;
      3: flag_pos = 5;
      4: flag_pos = 6;
      default: flag_pos = 7;
    endcase
  endfunction

  // Modulo-2^W count step: +1 on inc, -1 on dec, hold when both or neither.
  function automatic logic [3:0] cnt_step(input logic [3:0] cur,
                                          input logic inc, input logic dec);
    logic [3:0] nxt;
    nxt = cur;
    if (inc && !dec) nxt = cur + 4'd1;
    else if (dec && !inc) nxt = cur - 4'd1;
    return nxt;
  endfunction

  typedef struct packed {
    logic perr;
    logic ferr;
  } err_tag_t;

endpackage

// File: rtl/rxst_tag_fifo.sv
module rxst_tag_fifo
  import rxst_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     push,
  input  err_tag_t push_tag,
  input  logic     pop,
  output logic     push_acc,
  output logic     pop_acc,
  output err_tag_t head_tag,
  output logic     full,
  output logic     empty
);
  localparam int AW = $clog2(DEPTH);

  err_tag_t         mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [AW:0]      level;

  assign full     = (level == (AW+1)'(DEPTH));
  assign empty    = (level == '0);
  assign push_acc = push && !full;
  assign pop_acc  = pop && !empty;
  assign head_tag = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_acc) wr_ptr <= wr_ptr + 1'b1;
      if (pop_acc)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_acc, pop_acc})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rxst_err_count.sv
module rxst_err_count
  import rxst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       dec,
  output logic [3:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_step(cnt, inc, dec);
  end
endmodule

// File: rtl/rxst_flag_cell.sv
module rxst_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic rd_stb,
  input  logic wr_zero,
  output logic flag,
  output logic seen
);
  logic clr_ok;
  assign clr_ok = wr_zero && seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= RST_VAL;
      seen <= 1'b0;
    end else if (hw_set) begin
      flag <= 1'b1;
      seen <= 1'b0;
    end else if (clr_ok) begin
      flag <= 1'b0;
      seen <= 1'b0;
    end else if (rd_stb && flag) begin
      seen <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rxerr_status.sv
module uart_rxerr_status
  import rxst_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_rd,
  input  logic                 cpu_wr,
  input  logic [REG_W-1:0]     cpu_wdata,
  output logic [REG_W-1:0]     cpu_rdata,
  input  logic                 rx_push,
  input  logic                 rx_push_perr,
  input  logic                 rx_push_ferr,
  input  logic                 rx_pop,
  input  logic [NUM_FLAGS-1:0] flag_set
);
  // Named internal events, visible to the bound checker.
  logic                 push_acc, pop_acc;
  logic                 fifo_full, fifo_empty;
  err_tag_t             head_tag, push_tag;
  logic [3:0]           perr_cnt, ferr_cnt;
  logic [NUM_FLAGS-1:0] flag_q, seen_q, wr_zero;

  assign push_tag = '{perr: rx_push_perr, ferr: rx_push_ferr};

  rxst_tag_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rx_push),
    .push_tag (push_tag),
    .pop      (rx_pop),
    .push_acc (push_acc),
    .pop_acc  (pop_acc),
    .head_tag (head_tag),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  rxst_err_count u_perr (
    .clk (clk), .rst_n (rst_n),
    .inc (push_acc && push_tag.perr),
    .dec (pop_acc && head_tag.perr),
    .cnt (perr_cnt)
  );

  rxst_err_count u_ferr (
    .clk (clk), .rst_n (rst_n),
    .inc (push_acc && push_tag.ferr),
    .dec (pop_acc && head_tag.ferr),
    .cnt (ferr_cnt)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assign wr_zero[i] = cpu_wr && !cpu_wdata[flag_pos(i)];
    rxst_flag_cell #(.RST_VAL(FLAG_RST[i])) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .hw_set  (flag_set[i]),
      .rd_stb  (cpu_rd),
      .wr_zero (wr_zero[i]),
      .flag    (flag_q[i]),
      .seen    (seen_q[i])
    );
  end

  always_comb begin
    cpu_rdata        = '0;
    cpu_rdata[15:12] = perr_cnt;
    cpu_rdata[11:8]  = ferr_cnt;
    cpu_rdata[3]     = head_tag.ferr;
    cpu_rdata[2]     = head_tag.perr;
    for (int i = 0; i < NUM_FLAGS; i++) cpu_rdata[flag_pos(i)] = flag_q[i];
  end
endmodule

// File: rtl/rxst_chk.sv
module rxst_chk
  import rxst_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cpu_wr,
  input logic [REG_W-1:0]     cpu_wdata,
  input logic [REG_W-1:0]     cpu_rdata,
  input logic                 rx_push,
  input logic                 rx_pop,
  input logic [NUM_FLAGS-1:0] flag_set,
  input logic [NUM_FLAGS-1:0] flag_q,
  input logic                 fifo_full,
  input logic                 fifo_empty,
  input logic                 push_acc,
  input logic                 pop_acc
);
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && rx_push && !rx_pop) |=> $stable(cpu_rdata[15:8])); // R12

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_acc && !pop_acc) |=> $stable(cpu_rdata[15:8])); // R9

  AST_UPPER_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_wdata[15:8] != cpu_rdata[15:8] && !rx_push && !rx_pop)
      |=> $stable(cpu_rdata[15:8])); // R3

  AST_HEAD_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_wdata[3:2] != cpu_rdata[3:2] && !rx_push && !rx_pop)
      |=> $stable(cpu_rdata[3:2])); // R4

  AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> (cpu_rdata[3:2] == 2'b00)); // R4

  AST_NO_WRITE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set == '0) |=> ((flag_q & ~$past(flag_q)) == '0)); // R5

  AST_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> ((~flag_q & $past(flag_q)) == '0)); // R6

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set != '0) |=> ((flag_q & $past(flag_set)) == $past(flag_set))); // R11
endmodule

bind uart_rxerr_status rxst_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_wr     (cpu_wr),
  .cpu_wdata  (cpu_wdata),
  .cpu_rdata  (cpu_rdata),
  .rx_push    (rx_push),
  .rx_pop     (rx_pop),
  .flag_set   (flag_set),
  .flag_q     (flag_q),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .push_acc   (push_acc),
  .pop_acc    (pop_acc)
);

// File: tb/tb_uart_rxerr_status.sv
module tb_uart_rxerr_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [15:0] cpu_wdata = '0;
  logic [15:0] cpu_rdata;
  logic        rx_push = 1'b0, rx_push_perr = 1'b0, rx_push_ferr = 1'b0, rx_pop = 1'b0;
  logic [5:0]  flag_set = '0;
  int          total = 0, bad = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  uart_rxerr_status dut (
    .clk (clk), .rst_n (rst_n), .cpu_rd (cpu_rd), .cpu_wr (cpu_wr),
    .cpu_wdata (cpu_wdata), .cpu_rdata (cpu_rdata), .rx_push (rx_push),
    .rx_push_perr (rx_push_perr), .rx_push_ferr (rx_push_ferr),
    .rx_pop (rx_pop), .flag_set (flag_set)
  );

  // {push, perr, ferr, pop, expected register after the cycle}
  localparam logic [19:0] VEC [0:8] = '{
    {4'b1100, 16'h1064},   // push P
    {4'b1010, 16'h1164},   // push F
    {4'b1110, 16'h2264},   // push PF
    {4'b0001, 16'h1268},   // pop P, head F
    {4'b1001, 16'h116C},   // pop F, push clean, head PF
    {4'b1101, 16'h1060},   // pop PF, push P, head clean
    {4'b0001, 16'h1064},   // pop clean, head P
    {4'b0001, 16'h0060},   // pop P, empty
    {4'b0001, 16'h0060}    // pop on empty ignored
  };

  task automatic cyc(input logic pu, input logic pe, input logic fe, input logic po,
                     input logic rd, input logic wr, input logic [15:0] wd,
                     input logic [5:0] fs);
    rx_push = pu; rx_push_perr = pe; rx_push_ferr = fe; rx_pop = po;
    cpu_rd = rd; cpu_wr = wr; cpu_wdata = wd; flag_set = fs;
    @(negedge clk);
    rx_push = 0; rx_push_perr = 0; rx_push_ferr = 0; rx_pop = 0;
    cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0; flag_set = '0;
  endtask

  task automatic check(input logic [15:0] exp, input string req);
    total++;
    if (cpu_rdata !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%04h expected 0x%04h", req, cpu_rdata, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(16'h0060, "R7 reset value");
    rst_n = 1'b1;
    @(negedge clk);
    check(16'h0060, "R7 after release");

    for (int i = 0; i < 9; i++) begin
      cyc(VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16], 0, 0, 16'h0, 6'h0);
      check(VEC[i][15:0], "R1 R9 R4 table step");
    end

    // Fill with 16 double-error bytes: counts wrap to zero.
    for (int i = 0; i < 16; i++) cyc(1, 1, 1, 0, 0, 0, 16'h0, 6'h0);
    check(16'h006C, "R2 full wrap");
    cyc(1, 1, 0, 0, 0, 0, 16'h0, 6'h0);
    check(16'h006C, "R12 push into full dropped");
    cyc(0, 0, 0, 1, 0, 0, 16'h0, 6'h0);
    check(16'hFF6C, "R9 pop from full");
    for (int i = 0; i < 15; i++) cyc(0, 0, 0, 1, 0, 0, 16'h0, 6'h0);
    check(16'h0060, "R4 drained empty");

    cyc(1, 1, 0, 0, 0, 0, 16'h0, 6'h0);
    check(16'h1064, "R1 one parity byte");
    cyc(0, 0, 0, 0, 0, 1, 16'h0000, 6'h0);
    check(16'h1064, "R6 R3 R4 write 0 without read");
    cyc(0, 0, 0, 0, 0, 1, 16'hFFFF, 6'h0);
    check(16'h1064, "R5 R3 write ones");
    cyc(0, 0, 0, 0, 1, 0, 16'h0, 6'h0);
    cyc(0, 0, 0, 0, 0, 1, 16'h0000, 6'h0);
    check(16'h1004, "R6 read then write 0 clears");
    cyc(0, 0, 0, 0, 0, 1, 16'hFFFF, 6'h0);
    check(16'h1004, "R5 ones do not set flags");

    cyc(0, 0, 0, 0, 0, 0, 16'h0, 6'b000010);
    check(16'h1006, "R8 set index 1 to bit 1");
    cyc(0, 0, 0, 0, 1, 0, 16'h0, 6'h0);
    cyc(0, 0, 0, 0, 0, 0, 16'h0, 6'b000010);
    cyc(0, 0, 0, 0, 0, 1, 16'h0000, 6'h0);
    check(16'h1006, "R10 set between read and write survives");
    cyc(0, 0, 0, 0, 1, 0, 16'h0, 6'h0);
    cyc(0, 0, 0, 0, 0, 1, 16'h0000, 6'h0);
    check(16'h1004, "R6 clear after fresh read");

    cyc(0, 0, 0, 0, 0, 0, 16'h0, 6'b000100);
    check(16'h1014, "R8 set index 2 to bit 4");
    cyc(0, 0, 0, 0, 1, 0, 16'h0, 6'h0);
    cyc(0, 0, 0, 0, 0, 1, 16'h0000, 6'b000100);
    check(16'h1014, "R11 set wins over clear");
    cyc(0, 0, 0, 0, 1, 0, 16'h0, 6'h0);
    cyc(0, 0, 0, 0, 0, 1, 16'h0000, 6'h0);
    check(16'h1004, "R6 clear after set-wins");

    cyc(0, 0, 0, 0, 0, 0, 16'h0, 6'b100001);
    check(16'h1085, "R8 set indices 5 and 0");
    cyc(0, 0, 0, 0, 1, 0, 16'h0, 6'h0);
    cyc(0, 0, 0, 0, 0, 1, 16'h0080, 6'h0);
    check(16'h1084, "R6 R5 only zero-written bit clears");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule